// File: doc/BRIEF.md
# Line Voltage Sag Detector

This block watches a stream of signed voltage samples and reports a sag when the sample magnitude stays under a programmable level for a programmed number of whole line cycles. A separate pulse marks where each line cycle ends. Once enough consecutive full cycles have stayed under the level, the active-low sag pin goes low. In the same clock, a one-cycle event pulse is raised so that the surrounding logic can set a sag flag in its status register.

The pin goes high again on the first valid sample whose magnitude reaches the level. A disable input forces the pin high and clears all progress. The sample interface is valid/ready, but the block never applies back-pressure: `smp_ready` is held high out of reset, and every sample presented with `smp_valid` is taken in that clock. Control inputs are sampled every clock.

Top module: `sag_detector`

## Requirements
- R1: The compared magnitude byte is bits [14:7] of the absolute value of the 16-bit two's-complement sample, which is the upper byte of the magnitude shifted left by one. The byte is 0xFF when the magnitude is 0x8000, which only happens for sample -32768.
- R2: A valid sample is below the level only when `lvl_cfg` is strictly greater than its magnitude byte. A byte equal to the level counts as above.
- R3: `lvl_cfg` values 0x00 and 0x01 both put the level at zero, so no sample is ever below.
- R4: With `cyc_cfg` = N (N ≥ 2), `sag_n` goes low in the clock after the `cyc_edge` that closes the (N-1)th consecutive full line cycle in which every valid sample was below the level.
- R5: `cyc_cfg` values 0 and 1 behave as 2, so a single full below-level cycle is enough.
- R6: A cycle counts only if it started at a `cyc_edge` while detection was enabled and no above-level sample has occurred since that edge. Any above-level sample clears the consecutive-cycle count.
- R7: `sag_n` returns high in the clock after any valid above-level sample.
- R8: `sag_evt` is high for exactly one clock, in the clock where `sag_n` falls. It does not repeat while the sag is held.
- R9: While `det_off` is 1, `sag_n` is high, `sag_evt` is low and the cycle count is cleared.
- R10: After reset, `sag_n` is high, `sag_evt` is low and the count is zero. The cycle in progress at that point does not count.
- R11: `smp_ready` is always high. A valid sample presented in the same clock as `cyc_edge` belongs to the cycle that is ending, and the cycle that follows starts clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_ready | output | 1 | Sample accept, always high |
| smp_data | input | 16 | Signed voltage sample |
| cyc_edge | input | 1 | One-clock pulse at the end of each line cycle |
| lvl_cfg | input | 8 | Sag level |
| cyc_cfg | input | 8 | Cycle setting, one more than the qualifying cycle count |
| det_off | input | 1 | Disables detection when 1 |
| sag_n | output | 1 | Sag indicator, active low |
| sag_evt | output | 1 | One-clock pulse when a sag is declared |

## Verification
A sample and a cycle boundary can arrive in the same clock. When they do, the sample must be judged as part of the ending cycle, and the same clock must also decide whether the next cycle starts clean. The bench presents an above-level sample and a below-level sample, each together with `cyc_edge`. With an above-level sample, it checks that no sag is declared and that the very next full cycle is enough to assert. With a below-level sample, it checks that the shared clock itself completes the qualifying cycle.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int unsigned SMP_W = 16;
  localparam int unsigned LVL_W = 8;
  localparam int unsigned CNT_W = 8;
endpackage

// File: rtl/sag_mag.sv
module sag_mag #(
  parameter int unsigned SMP_W = 16,
  parameter int unsigned LVL_W = 8
) (
  input  logic [SMP_W-1:0] smp,
  input  logic [LVL_W-1:0] lvl,
  output logic             below
);
  localparam logic [SMP_W-1:0] ONE     = SMP_W'(1);
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

  logic [SMP_W-1:0] mag;
  logic [LVL_W-1:0] mbyte;
  logic [LVL_W-1:0] eff_lvl;

  always_comb begin
    mag     = smp[SMP_W-1] ? (~smp + ONE) : smp;
    // magnitude shifted left by one, upper byte kept; saturate at full negative
    mbyte   = mag[SMP_W-1] ? '1 : mag[SMP_W-2 -: LVL_W];
    eff_lvl = (lvl <= LVL_ONE) ? '0 : lvl;
    below   = eff_lvl > mbyte;
  end
endmodule

// File: rtl/sag_track.sv
module sag_track #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             off,
  input  logic             smp_above,
  input  logic             cyc_edge,
  input  logic [CNT_W-1:0] cfg,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CFG_TWO = CNT_W'(2);
  localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             clean;
  logic [CNT_W-1:0] target;
  logic [CNT_W:0]   nxt;

  always_comb begin
    target = (cfg < CFG_TWO) ? C_ONE : (cfg - C_ONE);
    nxt    = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    hit    = !off && cyc_edge && clean && !smp_above && (nxt >= {1'b0, target});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      clean <= 1'b0;
    end else if (off) begin
      cnt   <= '0;
      clean <= 1'b0;
    end else if (smp_above) begin
      cnt   <= '0;
      clean <= cyc_edge;
    end else if (cyc_edge) begin
      clean <= 1'b1;
      if (clean && cnt != '1) cnt <= nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/sag_out.sv
module sag_out (
  input  logic clk,
  input  logic rst_n,
  input  logic off,
  input  logic smp_above,
  input  logic hit,
  output logic sag_n,
  output logic sag_evt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sag_n   <= 1'b1;
      sag_evt <= 1'b0;
    end else begin
      sag_evt <= 1'b0;
      if (off || smp_above) begin
        sag_n <= 1'b1;
      end else if (hit && sag_n) begin
        sag_n   <= 1'b0;
        sag_evt <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sag_detector.sv
module sag_detector
  import sag_pkg::*;
#(
  parameter int unsigned P_SMP_W = SMP_W,
  parameter int unsigned P_LVL_W = LVL_W,
  parameter int unsigned P_CNT_W = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  output logic               smp_ready,
  input  logic [P_SMP_W-1:0] smp_data,
  input  logic               cyc_edge,
  input  logic [P_LVL_W-1:0] lvl_cfg,
  input  logic [P_CNT_W-1:0] cyc_cfg,
  input  logic               det_off,
  output logic               sag_n,
  output logic               sag_evt
);
  logic smp_below;
  logic smp_above;
  logic hit;

  assign smp_ready = 1'b1;

  sag_mag #(.SMP_W(P_SMP_W), .LVL_W(P_LVL_W)) u_mag (
    .smp   (smp_data),
    .lvl   (lvl_cfg),
    .below (smp_below)
  );

  assign smp_above = smp_valid && !smp_below;

  sag_track #(.CNT_W(P_CNT_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .off       (det_off),
    .smp_above (smp_above),
    .cyc_edge  (cyc_edge),
    .cfg       (cyc_cfg),
    .hit       (hit)
  );

  sag_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .off       (det_off),
    .smp_above (smp_above),
    .hit       (hit),
    .sag_n     (sag_n),
    .sag_evt   (sag_evt)
  );
endmodule

// File: rtl/sag_detector_chk.sv
module sag_detector_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_ready,
  input logic smp_above,
  input logic det_off,
  input logic sag_n,
  input logic sag_evt
);
  AST_EVT_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    sag_evt |-> (!sag_n && $past(sag_n))); // R8
  AST_FALL_HAS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sag_n) |-> sag_evt); // R8
  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sag_evt |=> !sag_evt); // R8
  AST_RELEASE_ON_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_above |=> sag_n); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    det_off |=> (sag_n && !sag_evt)); // R9
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready); // R11
endmodule

bind sag_detector sag_detector_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_ready (smp_ready),
  .smp_above (smp_above),
  .det_off   (det_off),
  .sag_n     (sag_n),
  .sag_evt   (sag_evt)
);

// File: tb/sag_detector_tb.sv
module sag_detector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        cyc_edge = 1'b0;
  logic [7:0]  lvl_cfg = 8'h20;
  logic [7:0]  cyc_cfg = 8'd2;
  logic        det_off = 1'b0;
  logic        sag_n;
  logic        sag_evt;

  int checks = 0;
  int errors = 0;

  localparam logic [15:0] LOW  = 16'h0100;
  localparam logic [15:0] HIGH = 16'h4000;

  always #2 clk = ~clk;

  sag_detector u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .cyc_edge(cyc_edge), .lvl_cfg(lvl_cfg),
    .cyc_cfg(cyc_cfg), .det_off(det_off), .sag_n(sag_n), .sag_evt(sag_evt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive for one clock; on return, outputs reflect that clock
  task automatic step(input logic v, input logic [15:0] d, input logic e);
    smp_valid = v; smp_data = d; cyc_edge = e;
    @(negedge clk);
    smp_valid = 1'b0; smp_data = '0; cyc_edge = 1'b0;
  endtask

  task automatic line_cycle(input logic [15:0] d);
    for (int i = 0; i < 3; i++) step(1'b1, d, 1'b0);
    step(1'b0, '0, 1'b1);
  endtask

  task automatic release_and_prime();
    step(1'b1, HIGH, 1'b0);
    step(1'b0, '0, 1'b1);
  endtask

  task automatic t_reset();
    check("R10 sag_n after reset", sag_n, 1'b1);
    check("R10 sag_evt after reset", sag_evt, 1'b0);
    check("R11 ready", smp_ready, 1'b1);
  endtask

  task automatic t_assert_count();
    lvl_cfg = 8'h20; cyc_cfg = 8'd4;
    step(1'b0, '0, 1'b1);
    line_cycle(LOW);
    check("R4 cycle 1", sag_n, 1'b1);
    line_cycle(16'hF080); // -0x0F80, byte 0x1F
    check("R4 cycle 2", sag_n, 1'b1);
    line_cycle(LOW);
    check("R4 cycle 3 asserts", sag_n, 1'b0);
    check("R8 event pulse", sag_evt, 1'b1);
    step(1'b0, '0, 1'b0);
    check("R8 event one clock", sag_evt, 1'b0);
    line_cycle(LOW);
    check("R8 held low", sag_n, 1'b0);
    check("R8 no repeat", sag_evt, 1'b0);
  endtask

  task automatic t_release_equal();
    step(1'b1, 16'h1000, 1'b0); // byte 0x20 equals level
    check("R2 R7 equal releases", sag_n, 1'b1);
    check("R7 no event on release", sag_evt, 1'b0);
  endtask

  task automatic t_mag_byte();
    lvl_cfg = 8'hFF; cyc_cfg = 8'd2;
    step(1'b0, '0, 1'b1);
    line_cycle(16'h8100); // -0x7F00, byte 0xFE
    check("R1 negative byte below", sag_n, 1'b0);
    step(1'b1, 16'h8000, 1'b0);
    check("R1 full negative saturates", sag_n, 1'b1);
  endtask

  task automatic t_zero_level();
    cyc_cfg = 8'd2;
    for (int l = 0; l < 2; l++) begin
      lvl_cfg = 8'(l);
      step(1'b0, '0, 1'b1);
      line_cycle(16'h0000);
      line_cycle(16'h0000);
      check("R3 level zero never sags", sag_n, 1'b1);
    end
  endtask

  task automatic t_short_cfg();
    lvl_cfg = 8'h20;
    for (int c = 0; c < 2; c++) begin
      cyc_cfg = 8'(c);
      release_and_prime();
      line_cycle(LOW);
      check("R5 cfg 0/1 one cycle", sag_n, 1'b0);
    end
  endtask

  task automatic t_partial();
    lvl_cfg = 8'h20; cyc_cfg = 8'd3;
    step(1'b1, HIGH, 1'b0);
    line_cycle(LOW);
    check("R6 partial not counted", sag_n, 1'b1);
    line_cycle(LOW);
    check("R6 one full cycle", sag_n, 1'b1);
    step(1'b1, LOW, 1'b0);
    step(1'b1, HIGH, 1'b0);
    step(1'b0, '0, 1'b1);
    line_cycle(LOW);
    check("R6 count cleared", sag_n, 1'b1);
    line_cycle(LOW);
    check("R6 second full cycle", sag_n, 1'b0);
  endtask

  task automatic t_shared_clock();
    lvl_cfg = 8'h20; cyc_cfg = 8'd2;
    step(1'b1, HIGH, 1'b0);
    step(1'b1, LOW, 1'b0);
    step(1'b1, HIGH, 1'b1);
    check("R11 above with edge no sag", sag_n, 1'b1);
    line_cycle(LOW);
    check("R11 next cycle starts clean", sag_n, 1'b0);
    release_and_prime();
    step(1'b1, LOW, 1'b0);
    step(1'b1, LOW, 1'b1);
    check("R11 below with edge counts", sag_n, 1'b0);
    check("R11 event on shared clock", sag_evt, 1'b1);
  endtask

  task automatic t_disable();
    lvl_cfg = 8'h20; cyc_cfg = 8'd2;
    det_off = 1'b1;
    @(negedge clk);
    check("R9 off releases", sag_n, 1'b1);
    line_cycle(LOW);
    line_cycle(LOW);
    check("R9 off no sag", sag_n, 1'b1);
    check("R9 off no event", sag_evt, 1'b0);
    det_off = 1'b0;
    line_cycle(LOW);
    check("R9 R6 first cycle after enable partial", sag_n, 1'b1);
    line_cycle(LOW);
    check("R9 detects after enable", sag_n, 1'b0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_assert_count();
    t_release_equal();
    t_mag_byte();
    t_zero_level();
    t_short_cfg();
    t_partial();
    t_shared_clock();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule